// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block makes one output pulse each time a chosen edge shows up on an external trigger pin. The edge clears a 16-bit up-counter and starts it. Two compare values set where the pulse sits in the count. When the counter reaches the start compare value, the output flip-flop inverts. When it reaches the end compare value, the flip-flop inverts again. The pin that carries the output is gated by an enable bit. A one-cycle strobe marks each compare hit. After the pulse, the counter keeps running until it wraps. At the wrap it raises an overflow flag and stops until the next trigger.

Software sets up the block through a small write port. The port has three targets: a control word, the end compare value and the start compare value. The control word selects the trigger edge, the count-clock divider, one-shot operation and the output enable. It also carries a pair of bits that force the output flip-flop high or low. Some encodings are not allowed, and a compare value of zero is not allowed. Such a write changes nothing and raises an error strobe.

Top module: `oneshot_timer`

## Requirements
- R1: The trigger pin is sampled through two flip-flops. A valid edge restarts the counter from zero. The edge field (control bits [1:0]) picks the valid edge: 00 is falling, 01 is rising, 11 is both.
- R2: A hit on the start compare value (address 2) inverts the output flip-flop. A hit on the end compare value (address 1) also inverts it. Without a hit or an initial-level load, the flip-flop holds its value.
- R3: Let the divider be D = 2^sel, where sel is control bits [3:2] (00, 01 or 10). The trigger level is changed between clock edges; call the next edge E. The counter holds zero from the edge two edges after E. A compare hit on value c changes the output (c+1)·D edges after that.
- R4: After the end-compare hit, further compare hits are ignored until the next trigger edge.
- R5: When the counter steps from 0xFFFF to 0x0000, the overflow flag is set and counting stops. The next trigger edge clears the flag.
- R6: A trigger edge during a pulse restarts the count from zero. The output level does not change at that moment.
- R7: Control bit 7 forces the output flip-flop high and bit 6 forces it low. Writing both bits as 1 is not allowed: the whole write is ignored, the level is kept, and the error strobe goes high one cycle later.
- R8: An edge field of 10 is not allowed. Such a control write is ignored and raises the error strobe.
- R9: A divider field of 11 is not allowed. Such a control write is ignored and raises the error strobe.
- R10: A compare write of 0x0000 is rejected. The old value is kept, and the error strobe goes high one cycle later.
- R11: The output pin follows the flip-flop only while the enable bit (control bit 5) is 1. Otherwise the pin is 0. After reset the pin, the overflow flag and the error strobe are all 0.
- R12: While the one-shot bit (control bit 4) is 0, trigger edges are ignored.
- R13: Each compare hit drives its match strobe high for exactly one cycle. The strobe is registered on the same edge as the output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Write strobe for the configuration port |
| cfgAddr | input | 2 | Write target: 0 control, 1 end compare, 2 start compare |
| cfgData | input | 16 | Write data |
| trigIn | input | 1 | Asynchronous trigger pin |
| pulseOut | output | 1 | Pulse output, gated by the enable bit |
| ovfFlag | output | 1 | Counter wrapped since the last trigger |
| matchStart | output | 1 | One-cycle strobe on a start compare hit |
| matchEnd | output | 1 | One-cycle strobe on an end compare hit |
| cfgErr | output | 1 | One-cycle strobe after a rejected write |

## Verification
The properties assume the following about the inputs:
- Each clock carries at most one write.
- The start compare value differs from the end compare value.
- Neither compare value is changed while a pulse is running.
- No initial-level load lands on the same edge as a compare hit.

The stimulus keeps to these rules in three ways. It sets up compare values only while the counter is idle or already past its hits. It loads the initial level only while no pulse is running. It drives the trigger pin only on falling clock edges, far enough apart that the two-flop synchronizer always resolves a clean level.

// File: rtl/ost_pkg.sv
package ost_pkg;
  // write-port targets; the bench and software rely on these values
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_END   = 2'd1;
  localparam logic [1:0] ADDR_START = 2'd2;

  // trigger edge encodings
  localparam logic [1:0] EDGE_FALL = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_BAD  = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic restart;   // clear counter, re-arm compares
    logic tick;      // count enable after the divider
    logic ldEnd;     // accept end compare value
    logic ldStart;   // accept start compare value
    logic setHigh;   // force output flip-flop to 1
    logic setLow;    // force output flip-flop to 0
  } ctlStrb_t;
endpackage

// File: rtl/ost_ctrl.sv
module ost_ctrl
  import ost_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             trigIn,
  input  logic             wrap,
  output ctlStrb_t         strb,
  output logic             outEn,
  output logic             ovfFlag,
  output logic             cfgErr
);
  // control word layout
  localparam int B_PRE   = 2;
  localparam int B_MODE  = B_PRE + PRE_W;
  localparam int B_OEN   = B_MODE + 1;
  localparam int B_LOW   = B_MODE + 2;
  localparam int B_HIGH  = B_MODE + 3;
  localparam int DIV_LOG = (1 << PRE_W) - 2;
  localparam int PCNT_W  = (DIV_LOG > 0) ? DIV_LOG : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   trigPrev;
  logic                   trigNow;
  logic [1:0]             edgeSel;
  logic [PRE_W-1:0]       preSel;
  logic                   oneShot;
  logic                   running;
  logic [PCNT_W-1:0]      preCnt;
  logic [PCNT_W-1:0]      divLast;
  logic                   edgeHit;
  logic                   isCtrl;
  logic                   isCmp;
  logic                   ctrlBad;
  logic                   cmpBad;

  assign trigNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], trigIn};
      trigPrev <= trigNow;
    end
  end

  always_comb begin
    case (edgeSel)
      EDGE_FALL: edgeHit = trigPrev & ~trigNow;
      EDGE_RISE: edgeHit = trigNow & ~trigPrev;
      EDGE_BOTH: edgeHit = trigNow ^ trigPrev;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign isCtrl  = cfgWe && (cfgAddr == ADDR_CTRL);
  assign isCmp   = cfgWe && ((cfgAddr == ADDR_END) || (cfgAddr == ADDR_START));
  assign ctrlBad = (cfgData[1:0] == EDGE_BAD) || (&cfgData[B_PRE +: PRE_W])
                   || (cfgData[B_LOW] && cfgData[B_HIGH]);
  assign cmpBad  = (cfgData == '0);
  assign divLast = PCNT_W'((32'd1 << preSel) - 32'd1);

  always_comb begin
    strb         = '0;
    strb.restart = oneShot && edgeHit;
    strb.tick    = running && (preCnt == divLast);
    strb.ldEnd   = cfgWe && (cfgAddr == ADDR_END) && !cmpBad;
    strb.ldStart = cfgWe && (cfgAddr == ADDR_START) && !cmpBad;
    strb.setHigh = isCtrl && !ctrlBad && cfgData[B_HIGH];
    strb.setLow  = isCtrl && !ctrlBad && cfgData[B_LOW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeSel <= EDGE_FALL;
      preSel  <= '0;
      oneShot <= 1'b0;
      outEn   <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      cfgErr <= (isCtrl && ctrlBad) || (isCmp && cmpBad);
      if (isCtrl && !ctrlBad) begin
        edgeSel <= cfgData[1:0];
        preSel  <= cfgData[B_PRE +: PRE_W];
        oneShot <= cfgData[B_MODE];
        outEn   <= cfgData[B_OEN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      ovfFlag <= 1'b0;
      preCnt  <= '0;
    end else if (strb.restart) begin
      running <= 1'b1;
      ovfFlag <= 1'b0;
      preCnt  <= '0;
    end else begin
      if (wrap) begin
        running <= 1'b0;
        ovfFlag <= 1'b1;
      end
      if (running) preCnt <= strb.tick ? '0 : preCnt + PCNT_W'(1);
    end
  end
endmodule

// File: rtl/ost_dp.sv
module ost_dp
  import ost_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrb_t         strb,
  input  logic [CNT_W-1:0] cfgData,
  output logic             outFf,
  output logic             matchStart,
  output logic             matchEnd,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmpEnd;
  logic [CNT_W-1:0] cmpStart;
  logic             armed;
  logic             hitStart;
  logic             hitEnd;

  assign hitStart = strb.tick && armed && (count == cmpStart);
  assign hitEnd   = strb.tick && armed && (count == cmpEnd);
  assign wrap     = strb.tick && (count == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpEnd   <= CNT_TOP;
      cmpStart <= CNT_TOP;
    end else begin
      if (strb.ldEnd)   cmpEnd   <= cfgData;
      if (strb.ldStart) cmpStart <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      armed <= 1'b0;
    end else if (strb.restart) begin
      count <= '0;
      armed <= 1'b1;
    end else if (strb.tick) begin
      count <= count + CNT_W'(1);
      if (hitEnd) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outFf      <= 1'b0;
      matchStart <= 1'b0;
      matchEnd   <= 1'b0;
    end else begin
      matchStart <= hitStart;
      matchEnd   <= hitEnd;
      if (strb.setHigh)           outFf <= 1'b1;
      else if (strb.setLow)       outFf <= 1'b0;
      else if (hitStart ^ hitEnd) outFf <= ~outFf;
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import ost_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             trigIn,
  output logic             pulseOut,
  output logic             ovfFlag,
  output logic             matchStart,
  output logic             matchEnd,
  output logic             cfgErr
);
  ctlStrb_t strb;
  logic     outEn;
  logic     outFf;
  logic     wrap;

  ost_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .trigIn(trigIn), .wrap(wrap), .strb(strb), .outEn(outEn),
    .ovfFlag(ovfFlag), .cfgErr(cfgErr)
  );

  ost_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cfgData(cfgData), .outFf(outFf),
    .matchStart(matchStart), .matchEnd(matchEnd), .wrap(wrap)
  );

  assign pulseOut = outFf & outEn;
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk
  import ost_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     outEn,
  input logic     outFf,
  input logic     pulseOut,
  input logic     matchStart,
  input logic     matchEnd,
  input logic     ovfFlag,
  input logic     cfgErr,
  input logic     wrap,
  input ctlStrb_t strb
);
  p_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !outEn |-> !pulseOut);

  p_toggle_r13: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && (matchStart ^ matchEnd) |-> (outFf != $past(outFf)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !(matchStart ^ matchEnd) && !$past(strb.setHigh || strb.setLow)
      |-> (outFf == $past(outFf)));

  p_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && (matchStart || matchEnd) |-> $past(strb.tick));

  p_strobe_once_r13: assert property (@(posedge clk) disable iff (rst)
    matchStart |=> !matchStart);

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    wrap && !strb.restart |=> ovfFlag);

  p_ovf_clr_r5: assert property (@(posedge clk) disable iff (rst)
    strb.restart |=> !ovfFlag);

  p_reject_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && cfgErr
      |-> !$past(strb.ldEnd || strb.ldStart || strb.setHigh || strb.setLow));
endmodule

bind oneshot_timer oneshot_timer_chk u_chk (
  .clk(clk), .rst(rst), .outEn(outEn), .outFf(outFf), .pulseOut(pulseOut),
  .matchStart(matchStart), .matchEnd(matchEnd), .ovfFlag(ovfFlag),
  .cfgErr(cfgErr), .wrap(wrap), .strb(strb)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [15:0] cfgData = 16'd0;
  logic        trigIn = 1'b0;
  logic        pulseOut, ovfFlag, matchStart, matchEnd, cfgErr;

  int nChecks = 0;
  int nBad    = 0;
  int cyc     = 0;
  logic monEn   = 1'b0;
  logic lastOut = 1'b0;

  typedef struct { int at; logic lvl; } ev_t;
  ev_t expQ[$];

  oneshot_timer u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .trigIn(trigIn), .pulseOut(pulseOut), .ovfFlag(ovfFlag),
    .matchStart(matchStart), .matchEnd(matchEnd), .cfgErr(cfgErr)
  );

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  // monitor: pops expected output changes and compares time and level
  always @(negedge clk) begin
    if (!rst && monEn && (pulseOut !== lastOut)) begin
      if (expQ.size() == 0) begin
        chk("R4 unexpected output change", 1, 0);
      end else begin
        ev_t e;
        e = expQ.pop_front();
        chk("R3 change cycle", cyc, e.at);
        chk("R2 change level", int'(pulseOut), int'(e.lvl));
      end
    end
    lastOut = pulseOut;
  end

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic kick(input logic lvl, output int n);
    @(negedge clk);
    trigIn = lvl;
    n = cyc;
  endtask

  task automatic push(input int at, input logic lvl);
    ev_t e;
    e.at = at; e.lvl = lvl;
    expQ.push_back(e);
  endtask

  // driver: trigger and push the two expected output changes (cs < ce)
  task automatic fire(input logic lvl, input int cs, input int ce, input int d,
                      input logic startLvl, output int n);
    kick(lvl, n);
    push(n + 3 + (cs + 1) * d, ~startLvl);
    push(n + 3 + (ce + 1) * d, startLvl);
  endtask

  task automatic monOn();
    @(negedge clk);
    monEn = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n, m;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset pulseOut", pulseOut, 0);
    chk("R11 reset ovfFlag", ovfFlag, 0);
    chk("R11 reset cfgErr", cfgErr, 0);

    wr(2'd2, 16'd5);
    chk("R10 nonzero accepted", cfgErr, 0);
    wr(2'd1, 16'd9);

    // R12: one-shot bit clear, trigger ignored
    wr(2'd0, 16'h0061);
    kick(1'b1, n);
    waitUntil(n + 9);
    chk("R12 no pulse when mode off", pulseOut, 0);
    chk("R12 no match when mode off", matchStart, 0);
    waitUntil(n + 20);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R1/R2/R13: rising edge, divide by 1
    wr(2'd0, 16'h0071);
    monOn();
    fire(1'b1, 5, 9, 1, 1'b0, n);
    waitUntil(n + 9);
    chk("R13 start strobe", matchStart, 1);
    chk("R1 rising edge pulse high", pulseOut, 1);
    waitUntil(n + 10);
    chk("R13 start strobe one cycle", matchStart, 0);
    waitUntil(n + 13);
    chk("R13 end strobe", matchEnd, 1);
    chk("R2 pulse ended", pulseOut, 0);
    waitUntil(n + 20);
    trigIn = 1'b0;
    repeat (10) @(negedge clk);

    // R3: divide by 4
    wr(2'd0, 16'h0039);
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd6);
    fire(1'b1, 3, 6, 4, 1'b0, n);
    waitUntil(n + 18);
    chk("R3 divided before start", pulseOut, 0);
    waitUntil(n + 19);
    chk("R3 divided start", pulseOut, 1);
    waitUntil(n + 35);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R1: falling edge select
    wr(2'd0, 16'h0030);
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd7);
    @(negedge clk); trigIn = 1'b1;
    repeat (10) @(negedge clk);
    fire(1'b0, 2, 7, 1, 1'b0, n);
    waitUntil(n + 6);
    chk("R1 falling edge pulse", pulseOut, 1);
    waitUntil(n + 15);

    // R1: both edges
    wr(2'd0, 16'h0033);
    fire(1'b1, 2, 7, 1, 1'b0, n);
    waitUntil(n + 6);
    chk("R1 both edges, rising", pulseOut, 1);
    waitUntil(n + 15);
    fire(1'b0, 2, 7, 1, 1'b0, n);
    waitUntil(n + 6);
    chk("R1 both edges, falling", pulseOut, 1);
    waitUntil(n + 15);

    // R7: initial level high gives inverted pulse
    monEn = 1'b0;
    wr(2'd0, 16'h00B1);
    chk("R7 init high", pulseOut, 1);
    monOn();
    fire(1'b1, 2, 7, 1, 1'b1, n);
    waitUntil(n + 6);
    chk("R7 inverted pulse low", pulseOut, 0);
    waitUntil(n + 15);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R7: both init bits rejected
    monEn = 1'b0;
    wr(2'd0, 16'h00F1);
    chk("R7 both init bits flagged", cfgErr, 1);
    chk("R7 both init bits level kept", pulseOut, 1);
    wr(2'd0, 16'h0071);
    chk("R7 init low accepted", cfgErr, 0);
    chk("R7 init low", pulseOut, 0);

    // R8/R9/R10: prohibited writes leave configuration alone
    wr(2'd0, 16'h0032);
    chk("R8 edge 10 flagged", cfgErr, 1);
    wr(2'd0, 16'h003D);
    chk("R9 divider 11 flagged", cfgErr, 1);
    wr(2'd1, 16'd0);
    chk("R10 zero compare flagged", cfgErr, 1);
    monOn();
    fire(1'b1, 2, 7, 1, 1'b0, n);
    waitUntil(n + 6);
    chk("R8 R9 rising, divide by 1 kept", pulseOut, 1);
    waitUntil(n + 11);
    chk("R10 old end value kept", pulseOut, 0);
    waitUntil(n + 15);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R11: output gated off while flip-flop toggles
    monEn = 1'b0;
    wr(2'd0, 16'h0011);
    kick(1'b1, n);
    waitUntil(n + 6);
    chk("R11 strobe while gated", matchStart, 1);
    chk("R11 pin held low", pulseOut, 0);
    waitUntil(n + 15);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R6: retrigger during pulse
    wr(2'd0, 16'h0031);
    wr(2'd2, 16'd5);
    wr(2'd1, 16'd20);
    monOn();
    kick(1'b1, n);
    push(n + 9, 1'b1);
    waitUntil(n + 10);
    trigIn = 1'b0;
    waitUntil(n + 12);
    kick(1'b1, m);
    push(m + 9, 1'b0);
    push(m + 24, 1'b1);
    waitUntil(m + 3);
    chk("R6 level kept at restart", pulseOut, 1);
    waitUntil(m + 4);
    chk("R6 level kept after restart", pulseOut, 1);
    waitUntil(m + 30);
    chk("R6 final level", pulseOut, 1);
    monEn = 1'b0;
    wr(2'd0, 16'h0071);
    chk("R7 restore low", pulseOut, 0);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R4: start hit after end hit is ignored
    wr(2'd2, 16'd10);
    wr(2'd1, 16'd4);
    monOn();
    kick(1'b1, n);
    push(n + 8, 1'b1);
    waitUntil(n + 14);
    chk("R4 no strobe after end", matchStart, 0);
    chk("R4 level held after end", pulseOut, 1);
    waitUntil(n + 20);
    monEn = 1'b0;
    wr(2'd0, 16'h0071);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R5: overflow and clear on next trigger
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd4);
    monOn();
    fire(1'b1, 2, 4, 1, 1'b0, n);
    waitUntil(n + 3 + 65535);
    chk("R5 no overflow before wrap", ovfFlag, 0);
    waitUntil(n + 3 + 65536);
    chk("R5 overflow at wrap", ovfFlag, 1);
    waitUntil(n + 3 + 65536 + 30);
    chk("R5 flag held after stop", ovfFlag, 1);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);
    fire(1'b1, 2, 4, 1, 1'b0, n);
    waitUntil(n + 4);
    chk("R5 flag cleared by trigger", ovfFlag, 0);
    waitUntil(n + 12);

    chk("R3 all expected changes seen", expQ.size(), 0);
    summary();
    $finish;
  end
endmodule